// File: doc/BRIEF.md
# Banked Auxiliary Control Register for a Modem Data Path

This block is the register front end of a modem transmit and receive path. It holds three control registers behind a small synchronous bus: an address, write data and a write strobe, with read data returned combinationally for the address presented. One bus address is shared by two registers. The third control register sits there normally. A shadow auxiliary register takes its place whenever a bank-select bit in the second control register is set. Clearing that bit makes the third control register visible again with its contents intact.

The auxiliary register mixes two kinds of bits. The live status bits show the transmit baud clock and the raw received data taken before the descrambler. The writable control bits hold a signal-quality threshold select and a transmit-source select. The block also drives the transmit data output. It picks either the external data pin or an alternate data bit held in the third control register. A pattern field in the first control register can force a constant mark, a constant space or an alternating pattern, and this overrides both sources. The modulator, descrambler and baud clock generator are outside this block and reach it as plain input signals.

Register addresses are `3'b011` for the first control register, `3'b100` for the second, and `3'b101` for the shared address. All other addresses read as zero and ignore writes.

Top module: `modem_auxreg`

## Requirements
- R1: On a synchronous active-high reset every register clears to zero. The normal bank is selected, reads of all three addresses return 0x00, and `qual_thresh` is 00.
- R2: With bit 6 of the second control register at 0, a write to address 3'b101 stores all 8 bits into the third control register, and a read of that address returns them.
- R3: With bit 6 of the second control register at 1, address 3'b101 reaches the auxiliary register. A write there leaves the third control register unchanged.
- R4: With bit 6 of the second control register at 0, a write to address 3'b101 leaves the auxiliary register's writable bits unchanged.
- R5: In the auxiliary register only bits 3, 2 and 1 store written data. Bits 7, 4 and 0 always read 0, and writes to bits 7 to 4 have no effect.
- R6: Auxiliary bit 6 reads the live level of `baud_clk_in`, and auxiliary bit 5 reads the live level of `rx_raw_in`.
- R7: With no pattern override, auxiliary bit 3 picks the transmit source. A value of 0 sends `txd_pin_in`. A value of 1 sends bit 7 of the third control register.
- R8: The pattern field is bits 7:6 of the first control register. Code 00 means no override, 01 forces `tx_data_out` to 1 (mark), and 10 forces it to 0 (space). Both sources are ignored while a code is active.
- R9: Pattern code 11 sends an alternating pattern. It starts at 1 when the code is entered and inverts once for each rising edge of `baud_clk_in`. A level held high gives only one inversion.
- R10: Auxiliary bits 2:1 hold the quality threshold select and drive `qual_thresh` directly. The default is 00.
- R11: After bit 6 of the second control register is cleared, address 3'b101 again reads the third control register with the value it held before the auxiliary bank was entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per clock while high |
| bus_rdata | output | 8 | Read data for the presented address (combinational) |
| baud_clk_in | input | 1 | Transmit baud-synchronous clock level |
| rx_raw_in | input | 1 | Received data before the descrambler |
| txd_pin_in | input | 1 | External transmit data pin |
| tx_data_out | output | 1 | Selected transmit data bit |
| qual_thresh | output | 2 | Signal-quality threshold select |

## Verification
The bench crosses the bank boundary in both directions. A design that decoded the shared address without the bank bit would overwrite the third control register from the auxiliary bank, or the reverse. That would show up as a changed value when the other bank is read back. It writes all ones to the auxiliary register, so any design that stored the status or unused bits would return a value other than 0x0E. It sets the source select with the alternate bit at both levels and then lets each pattern code override a pin driven to the opposite level. It holds the baud clock high over several cycles, so a design that toggled on level rather than on the rising edge would alternate more than once.

// File: rtl/auxreg_pkg.sv
package auxreg_pkg;

    localparam int REG_AW = 3;
    localparam int REG_DW = 8;

    localparam logic [REG_AW-1:0] ADDR_CR1 = 3'b011;
    localparam logic [REG_AW-1:0] ADDR_CR2 = 3'b100;
    localparam logic [REG_AW-1:0] ADDR_CR3 = 3'b101;

    // bit positions whose meaning other logic decodes
    localparam int BANK_BIT   = 6;   // in CR2
    localparam int ALT_BIT    = 7;   // in CR3
    localparam int PAT_HI_BIT = 7;   // in CR1
    localparam int PAT_LO_BIT = 6;   // in CR1

    typedef enum logic [1:0] {
        PAT_NONE  = 2'b00,
        PAT_MARK  = 2'b01,
        PAT_SPACE = 2'b10,
        PAT_ALT   = 2'b11
    } tx_pat_e;

    typedef struct packed {
        logic       src_alt;
        logic [1:0] thresh;
    } spec_ctl_t;

    typedef struct packed {
        logic baud;
        logic rx_raw;
    } spec_stat_t;

    function automatic spec_ctl_t unpack_special(input logic [REG_DW-1:0] w);
        spec_ctl_t c;
        c.src_alt = w[3];
        c.thresh  = w[2:1];
        return c;
    endfunction

    function automatic logic [REG_DW-1:0] pack_special(input spec_stat_t st,
                                                       input spec_ctl_t  c);
        return {1'b0, st.baud, st.rx_raw, 1'b0, c.src_alt, c.thresh, 1'b0};
    endfunction

endpackage

// File: rtl/auxreg_regs.sv
module auxreg_regs
    import auxreg_pkg::*;
#(
    parameter int AW = REG_AW,
    parameter int DW = REG_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          we,
    output logic [DW-1:0] cr1,
    output logic [DW-1:0] cr2,
    output logic [DW-1:0] cr3,
    output spec_ctl_t     spec,
    output logic          bank
);

    logic wr_cr1, wr_cr2, wr_shared;

    assign bank      = cr2[BANK_BIT];
    assign wr_cr1    = we && (addr == AW'(ADDR_CR1));
    assign wr_cr2    = we && (addr == AW'(ADDR_CR2));
    assign wr_shared = we && (addr == AW'(ADDR_CR3));

    always_ff @(posedge clk) begin
        if (rst) begin
            cr1  <= '0;
            cr2  <= '0;
            cr3  <= '0;
            spec <= '0;
        end else begin
            if (wr_cr1) cr1 <= wdata;
            if (wr_cr2) cr2 <= wdata;
            if (wr_shared) begin
                if (bank) spec <= unpack_special(REG_DW'(wdata));
                else      cr3  <= wdata;
            end
        end
    end

endmodule

// File: rtl/auxreg_txsel.sv
module auxreg_txsel
    import auxreg_pkg::*;
#(
    parameter logic ALT_START = 1'b1
) (
    input  logic    clk,
    input  logic    rst,
    input  tx_pat_e pat,
    input  logic    src_alt,
    input  logic    alt_bit,
    input  logic    pin,
    input  logic    baud,
    output logic    tx_out
);

    logic baud_q;
    logic phase;
    logic baud_rise;
    logic src_bit;

    assign baud_rise = baud && !baud_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            baud_q <= 1'b0;
            phase  <= 1'b0;
        end else begin
            baud_q <= baud;
            if (pat != PAT_ALT) phase <= 1'b0;
            else if (baud_rise) phase <= ~phase;
        end
    end

    assign src_bit = src_alt ? alt_bit : pin;

    always_comb begin
        unique case (pat)
            PAT_MARK:  tx_out = 1'b1;
            PAT_SPACE: tx_out = 1'b0;
            PAT_ALT:   tx_out = ALT_START ^ phase;
            default:   tx_out = src_bit;
        endcase
    end

endmodule

// File: rtl/auxreg_rdmux.sv
module auxreg_rdmux
    import auxreg_pkg::*;
#(
    parameter int AW = REG_AW,
    parameter int DW = REG_DW
) (
    input  logic [AW-1:0] addr,
    input  logic          bank,
    input  logic [DW-1:0] cr1,
    input  logic [DW-1:0] cr2,
    input  logic [DW-1:0] cr3,
    input  spec_ctl_t     spec,
    input  spec_stat_t    stat,
    output logic [DW-1:0] rdata
);

    always_comb begin
        if (addr == AW'(ADDR_CR1))      rdata = cr1;
        else if (addr == AW'(ADDR_CR2)) rdata = cr2;
        else if (addr == AW'(ADDR_CR3)) rdata = bank ? DW'(pack_special(stat, spec)) : cr3;
        else                            rdata = '0;
    end

endmodule

// File: rtl/modem_auxreg.sv
module modem_auxreg
    import auxreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_we,
    output logic [7:0] bus_rdata,
    input  logic       baud_clk_in,
    input  logic       rx_raw_in,
    input  logic       txd_pin_in,
    output logic       tx_data_out,
    output logic [1:0] qual_thresh
);

    logic [REG_DW-1:0] cr1_q, cr2_q, cr3_q;
    spec_ctl_t         spec_q;
    spec_stat_t        stat;
    logic              bank_sel;
    tx_pat_e           pat;

    assign stat.baud   = baud_clk_in;
    assign stat.rx_raw = rx_raw_in;
    assign pat         = tx_pat_e'(cr1_q[PAT_HI_BIT:PAT_LO_BIT]);
    assign qual_thresh = spec_q.thresh;

    auxreg_regs #(.AW(REG_AW), .DW(REG_DW)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .we    (bus_we),
        .cr1   (cr1_q),
        .cr2   (cr2_q),
        .cr3   (cr3_q),
        .spec  (spec_q),
        .bank  (bank_sel)
    );

    auxreg_rdmux #(.AW(REG_AW), .DW(REG_DW)) u_rdmux (
        .addr  (bus_addr),
        .bank  (bank_sel),
        .cr1   (cr1_q),
        .cr2   (cr2_q),
        .cr3   (cr3_q),
        .spec  (spec_q),
        .stat  (stat),
        .rdata (bus_rdata)
    );

    auxreg_txsel #(.ALT_START(1'b1)) u_txsel (
        .clk     (clk),
        .rst     (rst),
        .pat     (pat),
        .src_alt (spec_q.src_alt),
        .alt_bit (cr3_q[ALT_BIT]),
        .pin     (txd_pin_in),
        .baud    (baud_clk_in),
        .tx_out  (tx_data_out)
    );

endmodule

// File: rtl/modem_auxreg_chk.sv
module modem_auxreg_chk
    import auxreg_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [2:0] bus_addr,
    input logic       bus_we,
    input logic [7:0] bus_rdata,
    input logic       baud_clk_in,
    input logic       rx_raw_in,
    input logic       tx_data_out,
    input logic [1:0] cr1_pat,
    input logic [7:0] cr3_q,
    input spec_ctl_t  spec_q,
    input logic       bank_sel
);

    logic shared_wr;
    assign shared_wr = bus_we && (bus_addr == ADDR_CR3);

    p_aux_write_keeps_cr3_r3: assert property (@(posedge clk) disable iff (rst)
        (shared_wr && bank_sel) |=> $stable(cr3_q));

    p_norm_write_keeps_aux_r4: assert property (@(posedge clk) disable iff (rst)
        (shared_wr && !bank_sel) |=> $stable(spec_q));

    p_unused_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (bank_sel && bus_addr == ADDR_CR3) |-> (bus_rdata[7] == 1'b0 && bus_rdata[4] == 1'b0 && bus_rdata[0] == 1'b0));

    p_live_status_r6: assert property (@(posedge clk) disable iff (rst)
        (bank_sel && bus_addr == ADDR_CR3) |-> (bus_rdata[6] == baud_clk_in && bus_rdata[5] == rx_raw_in));

    p_mark_override_r8: assert property (@(posedge clk) disable iff (rst)
        (cr1_pat == 2'b01) |-> tx_data_out);

    p_space_override_r8: assert property (@(posedge clk) disable iff (rst)
        (cr1_pat == 2'b10) |-> !tx_data_out);

endmodule

bind modem_auxreg modem_auxreg_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_rdata   (bus_rdata),
    .baud_clk_in (baud_clk_in),
    .rx_raw_in   (rx_raw_in),
    .tx_data_out (tx_data_out),
    .cr1_pat     (cr1_q[7:6]),
    .cr3_q       (cr3_q),
    .spec_q      (spec_q),
    .bank_sel    (bank_sel)
);

// File: tb/tb_modem_auxreg.sv
module tb_modem_auxreg;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic       baud_clk_in = 1'b0;
    logic       rx_raw_in = 1'b0;
    logic       txd_pin_in = 1'b0;
    logic       tx_data_out;
    logic [1:0] qual_thresh;

    always #5 clk = ~clk;

    modem_auxreg dut (
        .clk         (clk),
        .rst         (rst),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_we      (bus_we),
        .bus_rdata   (bus_rdata),
        .baud_clk_in (baud_clk_in),
        .rx_raw_in   (rx_raw_in),
        .txd_pin_in  (txd_pin_in),
        .tx_data_out (tx_data_out),
        .qual_thresh (qual_thresh)
    );

    localparam logic [2:0] A1 = 3'b011;
    localparam logic [2:0] A2 = 3'b100;
    localparam logic [2:0] A3 = 3'b101;

    typedef enum int { K_RD, K_TX, K_QT } kind_e;
    typedef struct {
        string      req;
        kind_e      kind;
        logic [7:0] exp;
    } item_t;

    item_t q[$];
    event  sample_ev;
    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;

    // monitor: pops expectations and compares against the live outputs
    initial begin
        forever begin
            @(sample_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = q.pop_front();
                case (it.kind)
                    K_RD:    act = bus_rdata;
                    K_TX:    act = {7'd0, tx_data_out};
                    default: act = {6'd0, qual_thresh};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d actual=0x%02h expected=0x%02h", it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic expect_item(input string req, input kind_e k, input logic [7:0] e);
        item_t it;
        it.req = req; it.kind = k; it.exp = e;
        q.push_back(it);
        #1;
        -> sample_ev;
        #1;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string req);
        @(negedge clk);
        bus_addr = a;
        expect_item(req, K_RD, e);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic tx_is(input logic e, input string req);
        @(negedge clk);
        expect_item(req, K_TX, {7'd0, e});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A1, 8'h00, "R1");
        rd(A2, 8'h00, "R1");
        rd(A3, 8'h00, "R1");
        expect_item("R1", K_QT, 8'h00);
        expect_item("R10", K_QT, 8'h00);
        // R7 pin source by default
        txd_pin_in = 1'b1;
        tx_is(1'b1, "R7");
        txd_pin_in = 1'b0;
        tx_is(1'b0, "R7");

        // R2 normal bank
        wr(A3, 8'hA5);
        rd(A3, 8'hA5, "R2");

        // R3 enter auxiliary bank
        wr(A2, 8'h40);
        rd(A2, 8'h40, "R3");
        rd(A3, 8'h00, "R3");
        // R5 only bits 3:1 stored
        wr(A3, 8'hFF);
        rd(A3, 8'h0E, "R5");
        expect_item("R10", K_QT, 8'h03);
        // R7 alternate source, CR3 bit7 = 1, pin low
        tx_is(1'b1, "R7");

        // R6 live status bits
        baud_clk_in = 1'b1; rx_raw_in = 1'b0;
        rd(A3, 8'h4E, "R6");
        baud_clk_in = 1'b0; rx_raw_in = 1'b1;
        rd(A3, 8'h2E, "R6");
        rx_raw_in = 1'b0;

        // R11 leave bank, CR3 intact (R3: aux write did not touch it)
        wr(A2, 8'h00);
        rd(A3, 8'hA5, "R11");

        // R4 normal write leaves aux bits alone
        wr(A3, 8'h25);
        rd(A3, 8'h25, "R2");
        tx_is(1'b0, "R7");          // alternate bit now 0
        wr(A2, 8'h40);
        rd(A3, 8'h0E, "R4");
        wr(A3, 8'h02);
        rd(A3, 8'h02, "R10");
        expect_item("R10", K_QT, 8'h01);
        txd_pin_in = 1'b1;
        tx_is(1'b1, "R7");          // back to pin source

        // R8 overrides
        wr(A1, 8'h80);
        tx_is(1'b0, "R8");
        txd_pin_in = 1'b0;
        wr(A1, 8'h40);
        tx_is(1'b1, "R8");
        rd(A1, 8'h40, "R8");

        // R9 alternating pattern
        wr(A1, 8'hC0);
        tx_is(1'b1, "R9");
        @(negedge clk); baud_clk_in = 1'b1;
        tx_is(1'b0, "R9");
        repeat (3) @(negedge clk);
        tx_is(1'b0, "R9");          // held high: no extra toggle
        @(negedge clk); baud_clk_in = 1'b0;
        tx_is(1'b0, "R9");
        @(negedge clk); baud_clk_in = 1'b1;
        tx_is(1'b1, "R9");
        baud_clk_in = 1'b0;
        wr(A1, 8'h00);
        tx_is(1'b0, "R9");          // leaves pattern: pin=0 source

        repeat (2) @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule